// File: doc/BRIEF.md
# Programmable Bit Rate Clock Generator

This block supplies a serial-rate clock at sixteen times a chosen bit rate for a UART or similar transmitter and receiver. It runs entirely on one master clock. A free-running four-stage binary prescaler brings out its three low stages as taps, so external logic can build up to eight channel phases. The master clock itself is also brought out unchanged. Thirteen rate dividers run side by side. Each counts master clocks with its own fixed divisor. With a 2.4576 MHz master clock the divisors give the standard rates from 50 to 9600 baud at 16x. A slower master clock scales every rate down in proportion.

A 4-bit rate select chooses what appears on the registered rate output. Thirteen codes pick an internal rate. One code forces a steady low level. The two highest codes pass an external rate input through, which can carry a custom frequency or a static level for zero baud. A change of select takes effect at the next master clock edge and leaves the dividers running.

An initialization path clears the prescaler and all dividers. When the crystal-source select is low, the first clock on which the auxiliary clock pin is seen high clears the chain once. That pin is armed by the select falling from high to low. When the crystal-source select is high, a high auxiliary pin holds the chain in clear for as long as it stays high. All control pins are plain levels, and the block has no data stream or handshake.

Top module: `bitrate_gen`

## Requirements
- R1: While rst_n is low, pre_taps is 3'b000 and rate_clk is 0.
- R2: Outside a chain clear, pre_taps is a binary count of master clocks that increments by one on every clock and wraps from 7 to 0, so bit k has a period of 2^(k+1) clocks.
- R3: For rate_sel codes 0 to 12, rate_clk has a period of round(153600 / rate) master clocks. The rates in code order are 50, 75, 110, 134.5, 150, 200, 300, 600, 1200, 1800, 2400, 4800 and 9600, giving periods of 3072, 2048, 1396, 1142, 1024, 768, 512, 256, 128, 85, 64, 32 and 16.
- R4: For every even period N, rate_clk is high for exactly N/2 clocks. For the 1800 rate (code 9, N = 85), it is high for 43 clocks and low for 42.
- R5: With rate_sel equal to 4'd14 or 4'd15, rate_clk equals the value ext_rate had one master clock earlier.
- R6: With rate_sel equal to 4'd13, rate_clk is 0 from the second clock on.
- R7: While xtal_sel and aux_clk are both high, the chain is cleared, and pre_taps reads 0 two clocks after the pair was seen.
- R8: After xtal_sel falls, the first clock with aux_clk high (and xtal_sel low) clears the chain exactly once, and pre_taps reads 0 two clocks later. Later highs on aux_clk do not clear again until xtal_sel has risen and fallen again.
- R9: mclk_o carries the master clock unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xtal_sel | input | 1 | Clock-source select; high means the crystal source |
| aux_clk | input | 1 | Auxiliary clock pin, sampled for initialization |
| rate_sel | input | 4 | Rate code: 0 to 12 internal, 13 low, 14 and 15 external |
| ext_rate | input | 1 | External rate or static level for codes 14 and 15 |
| mclk_o | output | 1 | Copy of the master clock |
| pre_taps | output | 3 | Divide-by-2, -4 and -8 prescaler stages |
| rate_clk | output | 1 | Selected 16x rate clock, registered |

## Verification
Several properties are checked on every clock: each divider counter stays below its divisor, and each divider output rises only at the start of its period. The prescaler taps step by one whenever no clear is pending. The external pass-through and the forced-low code follow the select one clock later. A held crystal-mode clear zeroes the taps, and the initialization pulse never fires on two clocks in a row. The actual periods and high times of all thirteen rates need the bench scenarios, which count clocks between output edges. The bench scenarios also show that an armed initialization clears the chain once and that later aux_clk highs leave the count alone.

// File: rtl/brg_pkg.sv
package brg_pkg;
  localparam int RATE_COUNT = 13;
  localparam int DIV_W      = 12;
  localparam int ZERO_CODE  = 13;
  localparam int EXT_CODE   = 14;

  // master clocks per output period, nearest integer of 153600 / rate
  function automatic int rate_divisor(input int idx);
    case (idx)
      0:       return 3072;
      1:       return 2048;
      2:       return 1396;
      3:       return 1142;
      4:       return 1024;
      5:       return 768;
      6:       return 512;
      7:       return 256;
      8:       return 128;
      9:       return 85;
      10:      return 64;
      11:      return 32;
      default: return 16;
    endcase
  endfunction
endpackage

// File: rtl/brg_init.sv
module brg_init (
  input  logic clk,
  input  logic rst_n,
  input  logic xtal_sel,
  input  logic aux_clk,
  output logic chain_clr
);
  logic xtal_q;
  logic armed;
  logic fire;

  assign fire = armed & ~xtal_sel & aux_clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xtal_q    <= 1'b0;
      armed     <= 1'b0;
      chain_clr <= 1'b0;
    end else begin
      xtal_q <= xtal_sel;
      if (fire)
        armed <= 1'b0;
      else if (xtal_q && !xtal_sel)
        armed <= 1'b1;
      chain_clr <= fire | (xtal_sel & aux_clk);
    end
  end

  AST_SINGLE_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire); // R8
endmodule

// File: rtl/brg_prescaler.sv
module brg_prescaler #(
  parameter int PRE_W = 4,
  localparam int TAP_W = PRE_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [TAP_W-1:0] taps
);
  logic [PRE_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (clr)
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end

  assign taps = cnt[TAP_W-1:0];

  AST_TAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> taps == $past(taps) + 1'b1); // R2
endmodule

// File: rtl/brg_divider.sv
module brg_divider #(
  parameter int DIVISOR = 16,
  parameter int DIV_W   = 12,
  localparam int HIGH_LEN = (DIVISOR + 1) / 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic wave
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      wave <= 1'b0;
    end else if (clr) begin
      cnt  <= '0;
      wave <= 1'b0;
    end else begin
      cnt  <= (cnt == DIV_W'(DIVISOR - 1)) ? '0 : cnt + 1'b1;
      wave <= (cnt < DIV_W'(HIGH_LEN));
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < DIV_W'(DIVISOR)); // R3
  AST_RISE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wave) |-> cnt == DIV_W'(1)); // R4
endmodule

// File: rtl/bitrate_gen.sv
module bitrate_gen
  import brg_pkg::*;
#(
  parameter int PRE_W = 4,
  parameter int SEL_W = 4,
  localparam int TAP_W = PRE_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xtal_sel,
  input  logic             aux_clk,
  input  logic [SEL_W-1:0] rate_sel,
  input  logic             ext_rate,
  output logic             mclk_o,
  output logic [TAP_W-1:0] pre_taps,
  output logic             rate_clk
);
  logic                  chain_clr;
  logic [RATE_COUNT-1:0] div_out;
  logic                  pick;

  assign mclk_o = clk;

  brg_init u_init (
    .clk      (clk),
    .rst_n    (rst_n),
    .xtal_sel (xtal_sel),
    .aux_clk  (aux_clk),
    .chain_clr(chain_clr)
  );

  brg_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (chain_clr),
    .taps (pre_taps)
  );

  for (genvar i = 0; i < RATE_COUNT; i++) begin : g_rate
    brg_divider #(.DIVISOR(rate_divisor(i)), .DIV_W(DIV_W)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (chain_clr),
      .wave (div_out[i])
    );
  end

  always_comb begin
    pick = 1'b0;
    if (int'(rate_sel) >= EXT_CODE)
      pick = ext_rate;
    else if (int'(rate_sel) < RATE_COUNT)
      pick = div_out[rate_sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rate_clk <= 1'b0;
    else
      rate_clk <= pick;
  end

  AST_EXT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rate_sel) >= EXT_CODE) |=> rate_clk == $past(ext_rate)); // R5
  AST_ZERO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rate_sel) == ZERO_CODE) |=> !rate_clk); // R6
  AST_HOLD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (xtal_sel && aux_clk) |=> ##1 (pre_taps == '0)); // R7
endmodule

// File: tb/bitrate_gen_test.sv
module bitrate_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       xtal_sel = 1'b0;
  logic       aux_clk = 1'b0;
  logic [3:0] rate_sel = 4'd12;
  logic       ext_rate = 1'b0;
  logic       mclk_o;
  logic [2:0] pre_taps;
  logic       rate_clk;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk; // 250 MHz

  bitrate_gen uut (
    .clk(clk), .rst_n(rst_n), .xtal_sel(xtal_sel), .aux_clk(aux_clk),
    .rate_sel(rate_sel), .ext_rate(ext_rate), .mclk_o(mclk_o),
    .pre_taps(pre_taps), .rate_clk(rate_clk)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(pre_taps == 3'd0, "R1 taps in reset", pre_taps, 0);
    chk(rate_clk == 1'b0, "R1 rate_clk in reset", rate_clk, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_mclk();
    @(posedge clk); #1;
    chk(mclk_o == 1'b1, "R9 mclk high", mclk_o, 1);
    @(negedge clk); #1;
    chk(mclk_o == 1'b0, "R9 mclk low", mclk_o, 0);
  endtask

  task automatic t_taps();
    int bad = 0;
    logic [2:0] prev;
    @(negedge clk);
    prev = pre_taps;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (pre_taps != prev + 3'd1) bad++;
      prev = pre_taps;
    end
    chk(bad == 0, "R2 taps count step", bad, 0);
  endtask

  task automatic wait_rise();
    logic prv;
    prv = rate_clk;
    for (int g = 0; g < 5000; g++) begin
      @(negedge clk);
      if (rate_clk && !prv) break;
      prv = rate_clk;
    end
  endtask

  task automatic t_rate(input int code, input real baud);
    int exp_per, exp_hi, per, hi;
    logic cur, prv;
    exp_per = $rtoi(153600.0 / baud + 0.5);
    exp_hi  = (exp_per + 1) / 2;
    @(negedge clk);
    rate_sel = 4'(code);
    wait_rise();
    wait_rise();
    per = 0; hi = 0; cur = rate_clk;
    for (int g = 0; g < 5000; g++) begin
      per++;
      if (cur) hi++;
      prv = cur;
      @(negedge clk);
      cur = rate_clk;
      if (cur && !prv) break;
    end
    chk(per == exp_per, $sformatf("R3 period code %0d", code), per, exp_per);
    chk(hi == exp_hi, $sformatf("R4 high time code %0d", code), hi, exp_hi);
  endtask

  task automatic t_ext(input int code);
    int bad = 0;
    logic v;
    @(negedge clk);
    rate_sel = 4'(code);
    for (int i = 0; i < 12; i++) begin
      v = ((i * 5 + code) % 3) == 0;
      ext_rate = v;
      @(negedge clk);
      if (rate_clk != v) bad++;
    end
    chk(bad == 0, $sformatf("R5 ext pass code %0d", code), bad, 0);
  endtask

  task automatic t_zero();
    int highs = 0;
    @(negedge clk);
    rate_sel = 4'd13;
    @(negedge clk);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (rate_clk) highs++;
    end
    chk(highs == 0, "R6 forced low", highs, 0);
  endtask

  task automatic t_hold();
    int bad = 0;
    @(negedge clk);
    xtal_sel = 1'b1;
    aux_clk  = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pre_taps != 3'd0) bad++;
    end
    chk(bad == 0, "R7 held clear", bad, 0);
    aux_clk = 1'b0;
    @(negedge clk);
    chk(pre_taps == 3'd0, "R7 release first", pre_taps, 0);
    @(negedge clk);
    chk(pre_taps == 3'd1, "R7 release count", pre_taps, 1);
  endtask

  task automatic t_init();
    int bad = 0;
    logic [2:0] expv;
    @(negedge clk);
    xtal_sel = 1'b0;
    for (int g = 0; g < 20; g++) begin
      @(negedge clk);
      if (pre_taps == 3'd3) break;
    end
    aux_clk = 1'b1;
    @(negedge clk);
    chk(pre_taps == 3'd4, "R8 before clear", pre_taps, 4);
    @(negedge clk);
    chk(pre_taps == 3'd0, "R8 armed clear", pre_taps, 0);
    expv = 3'd0;
    for (int i = 0; i < 40; i++) begin
      if (i == 15) aux_clk = 1'b0;
      if (i == 20) aux_clk = 1'b1;
      @(negedge clk);
      expv = expv + 3'd1;
      if (pre_taps != expv) bad++;
    end
    chk(bad == 0, "R8 single clear only", bad, 0);
    aux_clk = 1'b0;
  endtask

  task automatic run_all();
    t_reset();
    t_mclk();
    t_taps();
    t_rate(0, 50.0);
    t_rate(1, 75.0);
    t_rate(2, 110.0);
    t_rate(3, 134.5);
    t_rate(4, 150.0);
    t_rate(5, 200.0);
    t_rate(6, 300.0);
    t_rate(7, 600.0);
    t_rate(8, 1200.0);
    t_rate(9, 1800.0);
    t_rate(10, 2400.0);
    t_rate(11, 4800.0);
    t_rate(12, 9600.0);
    t_ext(14);
    t_ext(15);
    t_zero();
    t_hold();
    t_init();
  endtask

  task automatic watchdog();
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
  endtask

  initial begin
    fork
      run_all();
      watchdog();
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule